// File: doc/BRIEF.md
# Banked Two-Port Cache Data and Tag Array

This block stores the data and the tags of a two-way set-associative cache whose lines are 64 bytes long, and serves two independent 8-byte loads in every cycle. A line is interleaved over eight data banks, so each bank holds one 8-byte chunk of every line in every way. Address bits [5:3] name the bank that holds the requested chunk. Two loads finish together when they name different banks. When they name the same bank, load port 0 goes ahead and load port 1 is held back with a stall for one cycle.

Each load port has its own private copy of the tag array, so both hit checks run in parallel without sharing compare logic. A separate line-fill port writes a whole line into one chosen way in a single cycle. That write goes to all eight banks and to both tag copies at once, and both load ports are stalled in that cycle. A load response comes back one cycle after the request and carries a hit flag, the way that hit and the 8-byte chunk. Miss handling toward memory and store merging belong to other blocks.

Top module: `cache_data_array`

## Requirements
- R1: After reset no way of any set holds a valid tag. Every accepted load misses until a fill has been done, and no response is pending.
- R2: A load that is accepted in cycle T (valid high and stall low) gives exactly one response, with the response valid flag high, in cycle T+1. A stalled load and an idle port give no response.
- R3: A load that hits returns chunk k of the stored line, where k = addr[5:3] and chunk k is fill_data[64*k+63:64*k]. Bits addr[2:0] have no effect on the result.
- R4: The address splits into tag = addr[31:12] and set = addr[11:6]. A load whose tag matches no valid way of its set reports a miss, with the data at zero.
- R5: Two lines that share a set but sit in different ways both hit. The way flag reports the way that holds the line (0 or 1).
- R6: A fill overwrites only the named way of the named set. The line that was there misses from then on, and the other way is left as it was.
- R7: Two loads to different banks are both accepted in the same cycle, and neither port stalls.
- R8: When both ports load from the same bank, port 0 is accepted and port 1 sees its stall high in that same cycle. Port 0 never stalls except in a fill cycle.
- R9: Two loads of the very same 8-byte word (same bank, same set, same tag) still conflict: port 1 stalls.
- R10: In a fill cycle both load ports stall and neither gives a response. A load issued in the next cycle sees the new line.
- R11: Each port checks hit or miss against its own tag copy, so in one cycle one port can hit while the other misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd0_vld | input | 1 | Load request on port 0 |
| rd0_addr | input | 32 | Byte address of the port 0 load |
| rd0_stall | output | 1 | Port 0 load not accepted in this cycle (same cycle) |
| rd1_vld | input | 1 | Load request on port 1 |
| rd1_addr | input | 32 | Byte address of the port 1 load |
| rd1_stall | output | 1 | Port 1 load not accepted in this cycle (same cycle) |
| fill_vld | input | 1 | Write a whole line in this cycle |
| fill_addr | input | 32 | Address of the line being filled (tag and set are used) |
| fill_way | input | 1 | Way that receives the line |
| fill_data | input | 512 | Line contents, chunk k in bits [64k+63:64k] |
| rsp0_vld | output | 1 | Port 0 response valid |
| rsp0_hit | output | 1 | Port 0 load hit |
| rsp0_way | output | 1 | Way that hit for port 0 |
| rsp0_data | output | 64 | Port 0 load data, zero on a miss |
| rsp1_vld | output | 1 | Port 1 response valid |
| rsp1_hit | output | 1 | Port 1 load hit |
| rsp1_way | output | 1 | Way that hit for port 1 |
| rsp1_data | output | 64 | Port 1 load data, zero on a miss |

## Verification
If a bank is steered to the wrong port, the fault shows up on the very next response. That response then carries another line's chunk, or the chunk from the wrong offset, so the bench fills lines whose chunks each encode both a line id and a chunk number. If the two tag copies drift apart, the same address hits on one port and misses on the other, so both ports load the same lines. A fill that is not applied to both copies therefore shows within one cycle. A conflict that is missed or falsely reported appears in the same cycle on the stall outputs. It also appears one cycle later as a response that is extra or missing against the expected queue.

// File: rtl/cache_pkg.sv
`timescale 1ns/1ps
package cache_pkg;
    parameter int ADDR_W      = 32;
    parameter int LINE_BYTES  = 64;
    parameter int CHUNK_BYTES = 8;
    parameter int N_WAYS      = 2;
    parameter int N_PORTS     = 2;

    localparam int CHUNK_W  = CHUNK_BYTES * 8;
    localparam int LINE_W   = LINE_BYTES * 8;
    localparam int N_BANKS  = LINE_BYTES / CHUNK_BYTES;
    localparam int OFS_W    = $clog2(LINE_BYTES);
    localparam int BANK_LSB = $clog2(CHUNK_BYTES);
    localparam int BANK_W   = $clog2(N_BANKS);
    localparam int WAY_W    = (N_WAYS > 1) ? $clog2(N_WAYS) : 1;

    typedef logic [BANK_W-1:0] bank_t;
    typedef logic [WAY_W-1:0]  way_t;
    typedef logic [CHUNK_W-1:0] chunk_t;
endpackage

// File: rtl/cache_tag_copy.sv
`timescale 1ns/1ps
module cache_tag_copy
    import cache_pkg::*;
#(
    parameter int SETS  = 64,
    parameter int IDX_W = 6,
    parameter int TAG_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_en,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  way_t             wr_way,
    input  logic [TAG_W-1:0] wr_tag,
    output logic             hit,
    output way_t             hit_way
);
    typedef struct packed {
        logic hit;
        way_t way;
    } lookup_t;

    logic [SETS-1:0]  valid_q [N_WAYS];
    logic [TAG_W-1:0] tag_q   [N_WAYS][SETS];
    lookup_t lk_d, lk_q;

    always_comb begin
        lk_d = '0;
        if (lk_en) begin
            for (int w = 0; w < N_WAYS; w++) begin
                if (!lk_d.hit && valid_q[w][lk_idx] && (tag_q[w][lk_idx] == lk_tag)) begin
                    lk_d.hit = 1'b1;
                    lk_d.way = way_t'(w);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_q <= '0;
            for (int w = 0; w < N_WAYS; w++) valid_q[w] <= '0;
        end else begin
            lk_q <= lk_d;
            if (wr_en) valid_q[wr_way][wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) tag_q[wr_way][wr_idx] <= wr_tag;
    end

    assign hit     = lk_q.hit;
    assign hit_way = lk_q.way;
endmodule

// File: rtl/cache_data_bank.sv
`timescale 1ns/1ps
module cache_data_bank
    import cache_pkg::*;
#(
    parameter int SETS  = 64,
    parameter int IDX_W = 6
) (
    input  logic                          clk,
    input  logic                          rd_en,
    input  logic [IDX_W-1:0]              rd_idx,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  way_t                          wr_way,
    input  chunk_t                        wr_data,
    output logic [N_WAYS-1:0][CHUNK_W-1:0] rd_data
);
    logic [N_WAYS-1:0][CHUNK_W-1:0] mem_q [SETS];
    logic [N_WAYS-1:0][CHUNK_W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_idx][wr_way] <= wr_data;
        if (rd_en) rd_q <= mem_q[rd_idx];
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/cache_bank_arbiter.sv
`timescale 1ns/1ps
module cache_bank_arbiter
    import cache_pkg::*;
(
    input  logic               fill_vld,
    input  logic               rd0_vld,
    input  bank_t              rd0_bank,
    input  logic               rd1_vld,
    input  bank_t              rd1_bank,
    output logic               grant0,
    output logic               grant1,
    output logic               stall0,
    output logic               stall1,
    output logic [N_BANKS-1:0] bank_en,
    output logic [N_BANKS-1:0] bank_sel1
);
    logic clash;

    always_comb begin
        clash  = rd0_vld && rd1_vld && (rd0_bank == rd1_bank);
        stall0 = rd0_vld && fill_vld;
        stall1 = rd1_vld && (fill_vld || clash);
        grant0 = rd0_vld && !stall0;
        grant1 = rd1_vld && !stall1;
    end

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank_route
        logic want0, want1;
        assign want0        = grant0 && (rd0_bank == bank_t'(b));
        assign want1        = grant1 && (rd1_bank == bank_t'(b));
        assign bank_en[b]   = want0 || want1;
        assign bank_sel1[b] = want1 && !want0;
    end
endmodule

// File: rtl/cache_data_array.sv
`timescale 1ns/1ps
module cache_data_array
    import cache_pkg::*;
#(
    parameter int SETS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd0_vld,
    input  logic [ADDR_W-1:0] rd0_addr,
    output logic              rd0_stall,
    input  logic              rd1_vld,
    input  logic [ADDR_W-1:0] rd1_addr,
    output logic              rd1_stall,
    input  logic              fill_vld,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_way,
    input  logic [LINE_W-1:0] fill_data,
    output logic              rsp0_vld,
    output logic              rsp0_hit,
    output logic              rsp0_way,
    output logic [CHUNK_W-1:0] rsp0_data,
    output logic              rsp1_vld,
    output logic              rsp1_hit,
    output logic              rsp1_way,
    output logic [CHUNK_W-1:0] rsp1_data
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W - OFS_W;

    typedef struct packed {
        logic [N_PORTS-1:0]             vld;
        logic [N_PORTS-1:0][BANK_W-1:0] bank;
    } rsp_state_t;

    logic [N_PORTS-1:0][ADDR_W-1:0] req_addr;
    logic [N_PORTS-1:0]             req_vld;
    logic [N_PORTS-1:0]             grant;
    logic [N_PORTS-1:0]             hit;
    way_t                           hit_way [N_PORTS];
    chunk_t                         rdata   [N_PORTS];
    logic [N_BANKS-1:0]             bank_en, bank_sel1;
    logic [N_WAYS-1:0][CHUNK_W-1:0] bank_rd [N_BANKS];
    rsp_state_t                     st_d, st_q;

    assign req_addr[0] = rd0_addr;
    assign req_addr[1] = rd1_addr;
    assign req_vld[0]  = rd0_vld;
    assign req_vld[1]  = rd1_vld;

    cache_bank_arbiter u_arb (
        .fill_vld  (fill_vld),
        .rd0_vld   (rd0_vld),
        .rd0_bank  (rd0_addr[BANK_LSB +: BANK_W]),
        .rd1_vld   (rd1_vld),
        .rd1_bank  (rd1_addr[BANK_LSB +: BANK_W]),
        .grant0    (grant[0]),
        .grant1    (grant[1]),
        .stall0    (rd0_stall),
        .stall1    (rd1_stall),
        .bank_en   (bank_en),
        .bank_sel1 (bank_sel1)
    );

    for (genvar p = 0; p < N_PORTS; p++) begin : g_tag_copy
        cache_tag_copy #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
            .clk     (clk),
            .rst_n   (rst_n),
            .lk_en   (grant[p]),
            .lk_idx  (req_addr[p][OFS_W +: IDX_W]),
            .lk_tag  (req_addr[p][ADDR_W-1 -: TAG_W]),
            .wr_en   (fill_vld),
            .wr_idx  (fill_addr[OFS_W +: IDX_W]),
            .wr_way  (way_t'(fill_way)),
            .wr_tag  (fill_addr[ADDR_W-1 -: TAG_W]),
            .hit     (hit[p]),
            .hit_way (hit_way[p])
        );
    end

    for (genvar b = 0; b < N_BANKS; b++) begin : g_data_bank
        logic [IDX_W-1:0] idx;
        assign idx = bank_sel1[b] ? rd1_addr[OFS_W +: IDX_W] : rd0_addr[OFS_W +: IDX_W];
        cache_data_bank #(.SETS(SETS), .IDX_W(IDX_W)) u_bank (
            .clk     (clk),
            .rd_en   (bank_en[b]),
            .rd_idx  (idx),
            .wr_en   (fill_vld),
            .wr_idx  (fill_addr[OFS_W +: IDX_W]),
            .wr_way  (way_t'(fill_way)),
            .wr_data (fill_data[b*CHUNK_W +: CHUNK_W]),
            .rd_data (bank_rd[b])
        );
    end

    always_comb begin
        st_d = st_q;
        for (int p = 0; p < N_PORTS; p++) begin
            st_d.vld[p] = grant[p] && req_vld[p];
            if (grant[p]) st_d.bank[p] = req_addr[p][BANK_LSB +: BANK_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        for (int p = 0; p < N_PORTS; p++) begin
            rdata[p] = hit[p] ? bank_rd[st_q.bank[p]][hit_way[p]] : '0;
        end
    end

    assign rsp0_vld  = st_q.vld[0];
    assign rsp0_hit  = st_q.vld[0] && hit[0];
    assign rsp0_way  = hit_way[0][0];
    assign rsp0_data = rdata[0];
    assign rsp1_vld  = st_q.vld[1];
    assign rsp1_hit  = st_q.vld[1] && hit[1];
    assign rsp1_way  = hit_way[1][0];
    assign rsp1_data = rdata[1];
endmodule

// File: rtl/cache_array_chk.sv
`timescale 1ns/1ps
module cache_array_chk
    import cache_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               rd0_vld,
    input logic [ADDR_W-1:0]  rd0_addr,
    input logic               rd0_stall,
    input logic               rd1_vld,
    input logic [ADDR_W-1:0]  rd1_addr,
    input logic               rd1_stall,
    input logic               fill_vld,
    input logic               rsp0_vld,
    input logic               rsp0_hit,
    input logic [CHUNK_W-1:0] rsp0_data,
    input logic               rsp1_vld,
    input logic               rsp1_hit,
    input logic [CHUNK_W-1:0] rsp1_data
);
    logic same_bank;
    assign same_bank = rd0_addr[BANK_LSB +: BANK_W] == rd1_addr[BANK_LSB +: BANK_W];

    // R2
    accept0_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_vld && !rd0_stall) |=> rsp0_vld);
    // R2
    idle1_norsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd1_vld && !rd1_stall) |=> !rsp1_vld);
    // R8
    port0_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd0_stall |-> fill_vld);
    // R8
    same_bank_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_vld && rd1_vld && same_bank) |-> rd1_stall);
    // R7
    split_bank_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_vld && rd1_vld && !(rd0_vld && same_bank)) |-> !rd1_stall);
    // R10
    fill_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_vld |=> (!rsp0_vld && !rsp1_vld));
    // R4
    miss_zero0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp0_vld && !rsp0_hit) |-> (rsp0_data == '0));
    // R4
    miss_zero1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp1_vld && !rsp1_hit) |-> (rsp1_data == '0));
endmodule

bind cache_data_array cache_array_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd0_vld   (rd0_vld),
    .rd0_addr  (rd0_addr),
    .rd0_stall (rd0_stall),
    .rd1_vld   (rd1_vld),
    .rd1_addr  (rd1_addr),
    .rd1_stall (rd1_stall),
    .fill_vld  (fill_vld),
    .rsp0_vld  (rsp0_vld),
    .rsp0_hit  (rsp0_hit),
    .rsp0_data (rsp0_data),
    .rsp1_vld  (rsp1_vld),
    .rsp1_hit  (rsp1_hit),
    .rsp1_data (rsp1_data)
);

// File: tb/cache_data_array_tb.sv
`timescale 1ns/1ps
module cache_data_array_tb;
    localparam int SETS = 64;

    logic         clk = 0;
    logic         rst_n = 0;
    logic         rd0_vld = 0, rd1_vld = 0, fill_vld = 0, fill_way = 0;
    logic [31:0]  rd0_addr = 0, rd1_addr = 0, fill_addr = 0;
    logic [511:0] fill_data = 0;
    logic         rd0_stall, rd1_stall;
    logic         rsp0_vld, rsp0_hit, rsp0_way, rsp1_vld, rsp1_hit, rsp1_way;
    logic [63:0]  rsp0_data, rsp1_data;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    cache_data_array #(.SETS(SETS)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .rd0_vld(rd0_vld), .rd0_addr(rd0_addr), .rd0_stall(rd0_stall),
        .rd1_vld(rd1_vld), .rd1_addr(rd1_addr), .rd1_stall(rd1_stall),
        .fill_vld(fill_vld), .fill_addr(fill_addr), .fill_way(fill_way), .fill_data(fill_data),
        .rsp0_vld(rsp0_vld), .rsp0_hit(rsp0_hit), .rsp0_way(rsp0_way), .rsp0_data(rsp0_data),
        .rsp1_vld(rsp1_vld), .rsp1_hit(rsp1_hit), .rsp1_way(rsp1_way), .rsp1_data(rsp1_data)
    );

    // reference model
    logic         m_val  [2][SETS];
    logic [19:0]  m_tag  [2][SETS];
    logic [511:0] m_line [2][SETS];

    // scoreboard queues, one per port
    logic [65:0] exp_q0[$], exp_q1[$];
    string       tag_q0[$], tag_q1[$];

    function automatic logic [31:0] mk_addr(logic [19:0] t, logic [5:0] s, logic [2:0] b, logic [2:0] lo);
        return {t, s, b, lo};
    endfunction

    function automatic logic [511:0] mk_line(logic [15:0] id);
        logic [511:0] l;
        for (int k = 0; k < 8; k++) l[k*64 +: 64] = {id, 16'(k), ~id, 16'hA500 | 16'(k)};
        return l;
    endfunction

    function automatic logic [65:0] model_look(logic [31:0] a);
        logic [5:0]  s = a[11:6];
        logic [19:0] t = a[31:12];
        for (int w = 0; w < 2; w++)
            if (m_val[w][s] && m_tag[w][s] == t)
                return {1'b1, 1'(w), m_line[w][s][a[5:3]*64 +: 64]};
        return {1'b0, 1'b0, 64'h0};
    endfunction

    task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // driver: one cycle of stimulus, pushes expected responses
    task automatic cyc(bit v0, logic [31:0] a0, bit v1, logic [31:0] a1,
                       bit f, logic [31:0] fa, bit fw, logic [511:0] fd, string req);
        bit es0, es1;
        @(negedge clk);
        rd0_vld = v0; rd0_addr = a0; rd1_vld = v1; rd1_addr = a1;
        fill_vld = f; fill_addr = fa; fill_way = fw; fill_data = fd;
        #1;
        es0 = v0 && f;
        es1 = v1 && (f || (v0 && a0[5:3] == a1[5:3]));
        chk(rd0_stall == es0, req, "stall0", 128'(rd0_stall), 128'(es0));
        chk(rd1_stall == es1, req, "stall1", 128'(rd1_stall), 128'(es1));
        if (v0 && !es0) begin exp_q0.push_back(model_look(a0)); tag_q0.push_back(req); end
        if (v1 && !es1) begin exp_q1.push_back(model_look(a1)); tag_q1.push_back(req); end
        @(posedge clk);
        if (f) begin
            m_val[fw][fa[11:6]] = 1'b1;
            m_tag[fw][fa[11:6]] = fa[31:12];
            m_line[fw][fa[11:6]] = fd;
        end
        #1;
        rd0_vld = 0; rd1_vld = 0; fill_vld = 0;
    endtask

    task automatic rd(bit v0, logic [31:0] a0, bit v1, logic [31:0] a1, string req);
        cyc(v0, a0, v1, a1, 1'b0, 32'h0, 1'b0, 512'h0, req);
    endtask

    task automatic fill(logic [31:0] fa, bit fw, logic [15:0] id, string req);
        cyc(1'b0, 32'h0, 1'b0, 32'h0, 1'b1, fa, fw, mk_line(id), req);
    endtask

    // monitor
    initial begin
        logic [65:0] e;
        string t;
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && rsp0_vld) begin
                if (exp_q0.size() == 0) chk(1'b0, "R2", "unexpected rsp0", 128'(1), 128'(0));
                else begin
                    e = exp_q0.pop_front(); t = tag_q0.pop_front();
                    chk({rsp0_hit, rsp0_way, rsp0_data} == e, t, "port0 {hit,way,data}",
                        128'({rsp0_hit, rsp0_way, rsp0_data}), 128'(e));
                end
            end
            if (rst_n && rsp1_vld) begin
                if (exp_q1.size() == 0) chk(1'b0, "R2", "unexpected rsp1", 128'(1), 128'(0));
                else begin
                    e = exp_q1.pop_front(); t = tag_q1.pop_front();
                    chk({rsp1_hit, rsp1_way, rsp1_data} == e, t, "port1 {hit,way,data}",
                        128'({rsp1_hit, rsp1_way, rsp1_data}), 128'(e));
                end
            end
        end
    end

    // watchdog
    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    localparam logic [19:0] TA = 20'h00111, TB = 20'h00222, TC = 20'h00333;

    initial begin
        for (int w = 0; w < 2; w++)
            for (int s = 0; s < SETS; s++) begin m_val[w][s] = 0; m_tag[w][s] = 0; m_line[w][s] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1: quiet after reset
        chk(!rsp0_vld && !rsp1_vld, "R1", "rsp after reset", 128'({rsp0_vld, rsp1_vld}), 128'(0));
        chk(!rd0_stall && !rd1_stall, "R1", "stall after reset", 128'({rd0_stall, rd1_stall}), 128'(0));
        // R1: everything misses before any fill
        rd(1, mk_addr(TA, 6'd5, 3'd0, 3'd0), 1, mk_addr(20'h0, 6'd0, 3'd1, 3'd0), "R1");
        // R3 R7: fill line A into way 0 of set 5, read two chunks in different banks
        fill(mk_addr(TA, 6'd5, 3'd0, 3'd0), 1'b0, 16'h00A0, "R10");
        rd(1, mk_addr(TA, 6'd5, 3'd3, 3'd5), 1, mk_addr(TA, 6'd5, 3'd6, 3'd7), "R7");
        // R5: line B same set in way 1
        fill(mk_addr(TB, 6'd5, 3'd0, 3'd0), 1'b1, 16'h00B0, "R5");
        rd(1, mk_addr(TB, 6'd5, 3'd0, 3'd0), 1, mk_addr(TA, 6'd5, 3'd7, 3'd0), "R5");
        // R4: unmatched tag in a full set
        rd(1, mk_addr(TC, 6'd5, 3'd2, 3'd0), 0, 32'h0, "R4");
        // R8: bank clash, port 1 retries
        rd(1, mk_addr(TA, 6'd5, 3'd2, 3'd0), 1, mk_addr(TB, 6'd5, 3'd2, 3'd0), "R8");
        rd(0, 32'h0, 1, mk_addr(TB, 6'd5, 3'd2, 3'd0), "R8");
        // R9: same word on both ports
        rd(1, mk_addr(TA, 6'd5, 3'd4, 3'd0), 1, mk_addr(TA, 6'd5, 3'd4, 3'd0), "R9");
        rd(0, 32'h0, 1, mk_addr(TA, 6'd5, 3'd4, 3'd0), "R9");
        // R10: fill C over way 0 while both ports request
        cyc(1, mk_addr(TA, 6'd5, 3'd1, 3'd0), 1, mk_addr(TB, 6'd5, 3'd3, 3'd0),
            1'b1, mk_addr(TC, 6'd5, 3'd0, 3'd0), 1'b0, mk_line(16'h00C0), "R10");
        rd(1, mk_addr(TC, 6'd5, 3'd1, 3'd0), 1, mk_addr(TB, 6'd5, 3'd3, 3'd0), "R10");
        // R6: A gone, B untouched
        rd(1, mk_addr(TA, 6'd5, 3'd1, 3'd0), 1, mk_addr(TB, 6'd5, 3'd5, 3'd0), "R6");
        // R11: one port misses while the other hits
        rd(1, mk_addr(TB, 6'd6, 3'd0, 3'd0), 1, mk_addr(TB, 6'd5, 3'd6, 3'd0), "R11");
        rd(1, mk_addr(TC, 6'd5, 3'd7, 3'd0), 1, mk_addr(TA, 6'd5, 3'd6, 3'd0), "R11");
        // set boundaries
        fill(mk_addr(20'hFFFFF, 6'd63, 3'd0, 3'd0), 1'b1, 16'h0F3F, "R3");
        fill(mk_addr(20'h00000, 6'd0, 3'd0, 3'd0), 1'b0, 16'h0100, "R3");
        // R3 R7: chunk sweep with ignored low bits
        for (int k = 0; k < 8; k++) begin
            rd(1, mk_addr(20'hFFFFF, 6'd63, 3'(k), 3'(k)),
               1, mk_addr(20'h00000, 6'd0, 3'(k + 1), 3'(7 - k)), "R3");
        end
        // R8: port 0 alone never stalls, port 1 alone never stalls
        rd(1, mk_addr(20'h00000, 6'd0, 3'd2, 3'd0), 0, 32'h0, "R8");
        rd(0, 32'h0, 1, mk_addr(20'hFFFFF, 6'd63, 3'd2, 3'd0), "R7");
        repeat (3) @(posedge clk);
        #3;
        chk(exp_q0.size() == 0, "R2", "missing rsp0", 128'(exp_q0.size()), 128'(0));
        chk(exp_q1.size() == 0, "R2", "missing rsp1", 128'(exp_q1.size()), 128'(0));
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule